// File: doc/BRIEF.md
# Compare-Match Peripheral Timer

This block is a memory-mapped up-counting timer for a chip's peripheral fabric. A host sees ten 32-bit registers on a simple word-addressed write/read bus: a control word, a 12-bit prescaler, a flag word, an interrupt-mask word, three compare values, two capture slots and the live count. The counter advances on a qualified tick input, divided down by the prescaler. Two counting styles exist. In restart style, compare 1 sets the period. In free-running style, the count runs across the full range and wraps.

Each compare match and each wrap of the counter latches a sticky flag. Software clears a flag by writing a one to its bit. A single level interrupt combines the flags with the mask and with the enable bit. A software-reset bit returns the block to its reset state but keeps the enable, mode and clock-selection bits of the control word. The asynchronous reset pin clears everything, the control word included.

Top module: `cmp_timer`

## Requirements
- R1: The register index is byte address bits [5:2] and bits [1:0] are ignored. The indices are: 0 control, 1 prescaler, 2 flags, 3 mask, 4/5/6 compare 1/2/3, 7/8 capture, 9 count. Capture slots and indices 10 to 15 read zero, and writes to them have no effect.
- R2: On a control write, bits set in 0x7C14 are stored as zero. Control bit positions: enable 0, enable-mode 1, free-run 9, software reset 15.
- R3: In restart style (bit 9 clear), the counter step that follows the counter equalling compare 1 loads 0.
- R4: In free-running style, the counter wraps from all-ones to 0 and sets the rollover flag (flag bit 5).
- R5: A counter step that makes the count equal to compare N sets flag bit N-1 (bits 0 to 2).
- R6: Writing compare 1 in restart style clears the counter. Writing compare 2 or 3, or compare 1 in free-running style, leaves the counter unchanged.
- R7: Writing the flag word clears each flag whose written bit is 1 and keeps the rest. If a flag is set and cleared in the same cycle, the set wins.
- R8: The mask register stores bits [5:0] only.
- R9: The irq output is high exactly when (flags AND mask) is nonzero and the enable bit is set.
- R10: The prescaler stores 12 bits. With the block enabled, the counter steps once per (prescaler+1) cycles with tick_en high. The division phase restarts on a prescaler write or when enable rises.
- R11: Writing control with bit 15 set stores (written value AND 0x1FF, with the 0x7C14 bits cleared). It also clears prescaler, flags, mask and counter, and sets all compare registers to all-ones.
- R12: The asynchronous reset clears control, prescaler, flags, mask and counter, and sets the compare registers to all-ones.
- R13: A 0-to-1 change of enable with enable-mode set restarts the counter at 0. With enable-mode clear, the count is kept. With enable clear, the counter does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counting tick qualifier, fed to the prescaler |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench goes after the rollover edge on an 8-bit-counter instance, where the wrap must raise the rollover flag together with all three compare flags at their all-ones reset values. A design that missed the wrap or mis-sized the compare would show a wrong flag word. It also forces a flag clear into the same cycle as the match that sets that flag, so a design that lets the clear win reads 0 instead of 1. Other targets are the restart on a compare-1 write (only in restart style) and the rise of enable with and without enable-mode. A wrong choice there would leave a stale count or zero a count that should be kept. The soft reset is checked for keeping the low nine control bits while reloading every other register. The prescaler is checked by counting steps over a fixed run of ticks, which exposes an off-by-one divider.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  // word indices (decoded from byte address bits [5:2])
  localparam int WD_CTRL  = 0;
  localparam int WD_PRESC = 1;
  localparam int WD_STAT  = 2;
  localparam int WD_IEN   = 3;
  localparam int WD_CMP1  = 4;
  localparam int WD_CMP2  = 5;
  localparam int WD_CMP3  = 6;
  localparam int WD_CAP1  = 7;
  localparam int WD_CAP2  = 8;
  localparam int WD_COUNT = 9;

  // control bit positions
  localparam int CB_EN    = 0;
  localparam int CB_ENMOD = 1;
  localparam int CB_FRR   = 9;
  localparam int CB_SWR   = 15;

  localparam logic [31:0] CTRL_ZERO_MASK = 32'h0000_7C14;
  localparam logic [31:0] CTRL_KEEP_MASK = 32'h0000_01FF;

  localparam int NUM_CMP  = 3;
  localparam int FLAG_W   = 6;
  localparam int ROV_BIT  = 5;
  localparam int PRESC_W  = 12;
endpackage

// File: rtl/cmp_timer_presc.sv
module cmp_timer_presc #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             sync_clr_i,
  input  logic             tick_en,
  input  logic [DIV_W-1:0] div_i,
  output logic             step_o
);
  logic [DIV_W-1:0] phase_q, phase_d;
  logic             last_phase;

  assign last_phase = (phase_q >= div_i);

  always_comb begin
    phase_d = phase_q;
    step_o  = 1'b0;
    if (sync_clr_i) begin
      phase_d = '0;
    end else if (run_i && tick_en) begin
      if (last_phase) begin
        phase_d = '0;
        step_o  = 1'b1;
      end else begin
        phase_d = phase_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  // phase never exceeds the divider value (divider changes always clear it)
  p_phase_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= div_i);

  // no stepping without the enable
  p_no_step_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !step_o);
endmodule

// File: rtl/cmp_timer_core.sv
module cmp_timer_core #(
  parameter int CNT_W = 32,
  parameter int NCMP  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       step_i,
  input  logic                       restart_mode_i,
  input  logic                       clr_i,
  input  logic [NCMP-1:0][CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0]           cnt_o,
  output logic [NCMP-1:0]            hit_o,
  output logic                       wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, nxt_val;
  logic             at_top, at_period, advance;

  assign at_top    = (cnt_q == {CNT_W{1'b1}});
  assign at_period = restart_mode_i && (cnt_q == cmp_i[0]);
  assign advance   = step_i && !clr_i;
  assign nxt_val   = (at_top || at_period) ? '0 : cnt_q + 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)        cnt_d = '0;
    else if (step_i)  cnt_d = nxt_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar k = 0; k < NCMP; k++) begin : g_match
    assign hit_o[k] = advance && (nxt_val == cmp_i[k]);
  end

  assign wrap_o = advance && at_top;
  assign cnt_o  = cnt_q;

  p_period_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && restart_mode_i && !clr_i && cnt_q == cmp_i[0]) |=> (cnt_q == '0));

  p_top_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clr_i && at_top) |=> (cnt_q == '0));

  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [31:0]                   ctrl_q, ctrl_d;
  logic [PRESC_W-1:0]            presc_q, presc_d;
  logic [FLAG_W-1:0]             stat_q, stat_d;
  logic [FLAG_W-1:0]             ien_q, ien_d;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_q, cmp_d;

  logic [IDX_W-1:0]   widx;
  logic               wr_ctrl, wr_presc, wr_stat, wr_ien;
  logic [NUM_CMP-1:0] wr_cmp;
  logic               soft_rst, en_rise, cnt_clr, presc_clr;
  logic [31:0]        ctrl_wval;
  logic               step;
  logic [CNT_W-1:0]   cnt;
  logic [NUM_CMP-1:0] hit;
  logic               wrap;
  logic [FLAG_W-1:0]  set_vec, clr_vec;
  logic               unused_addr_bits;

  assign unused_addr_bits = ^reg_addr[1:0];

  // ---------------- write decode ----------------
  assign widx     = reg_addr[ADDR_W-1:2];
  assign wr_ctrl  = reg_we && (widx == IDX_W'(WD_CTRL));
  assign wr_presc = reg_we && (widx == IDX_W'(WD_PRESC));
  assign wr_stat  = reg_we && (widx == IDX_W'(WD_STAT));
  assign wr_ien   = reg_we && (widx == IDX_W'(WD_IEN));

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp_dec
    assign wr_cmp[k] = reg_we && (widx == IDX_W'(WD_CMP1 + k));
  end

  assign ctrl_wval = reg_wdata & ~CTRL_ZERO_MASK;
  assign soft_rst  = wr_ctrl && reg_wdata[CB_SWR];

  // ---------------- next-state ----------------
  assign set_vec = {wrap, {(FLAG_W-NUM_CMP-1){1'b0}}, hit};
  assign clr_vec = wr_stat ? reg_wdata[FLAG_W-1:0] : '0;

  always_comb begin
    ctrl_d  = ctrl_q;
    presc_d = presc_q;
    ien_d   = ien_q;
    cmp_d   = cmp_q;
    stat_d  = (stat_q & ~clr_vec) | set_vec;
    if (soft_rst) begin
      ctrl_d  = ctrl_wval & CTRL_KEEP_MASK;
      presc_d = '0;
      ien_d   = '0;
      stat_d  = '0;
      for (int k = 0; k < NUM_CMP; k++) cmp_d[k] = '1;
    end else begin
      if (wr_ctrl)  ctrl_d  = ctrl_wval;
      if (wr_presc) presc_d = reg_wdata[PRESC_W-1:0];
      if (wr_ien)   ien_d   = reg_wdata[FLAG_W-1:0];
      for (int k = 0; k < NUM_CMP; k++) begin
        if (wr_cmp[k]) cmp_d[k] = reg_wdata[CNT_W-1:0];
      end
    end
  end

  assign en_rise   = !ctrl_q[CB_EN] && ctrl_d[CB_EN];
  assign cnt_clr   = soft_rst || (en_rise && ctrl_d[CB_ENMOD]) ||
                     (wr_cmp[0] && !ctrl_q[CB_FRR]);
  assign presc_clr = soft_rst || wr_presc || en_rise;

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      presc_q <= '0;
      stat_q  <= '0;
      ien_q   <= '0;
      cmp_q   <= '1;
    end else begin
      ctrl_q  <= ctrl_d;
      presc_q <= presc_d;
      stat_q  <= stat_d;
      ien_q   <= ien_d;
      cmp_q   <= cmp_d;
    end
  end

  // ---------------- datapath ----------------
  cmp_timer_presc #(.DIV_W(PRESC_W)) i_presc (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (ctrl_q[CB_EN]),
    .sync_clr_i (presc_clr),
    .tick_en    (tick_en),
    .div_i      (presc_q),
    .step_o     (step)
  );

  cmp_timer_core #(.CNT_W(CNT_W), .NCMP(NUM_CMP)) i_core (
    .clk            (clk),
    .rst_n          (rst_n),
    .step_i         (step),
    .restart_mode_i (!ctrl_q[CB_FRR]),
    .clr_i          (cnt_clr),
    .cmp_i          (cmp_q),
    .cnt_o          (cnt),
    .hit_o          (hit),
    .wrap_o         (wrap)
  );

  // ---------------- read mux ----------------
  always_comb begin
    reg_rdata = '0;
    case (widx)
      IDX_W'(WD_CTRL):  reg_rdata = ctrl_q;
      IDX_W'(WD_PRESC): reg_rdata = 32'(presc_q);
      IDX_W'(WD_STAT):  reg_rdata = 32'(stat_q);
      IDX_W'(WD_IEN):   reg_rdata = 32'(ien_q);
      IDX_W'(WD_CMP1):  reg_rdata = 32'(cmp_q[0]);
      IDX_W'(WD_CMP2):  reg_rdata = 32'(cmp_q[1]);
      IDX_W'(WD_CMP3):  reg_rdata = 32'(cmp_q[2]);
      IDX_W'(WD_COUNT): reg_rdata = 32'(cnt);
      default:          reg_rdata = '0;
    endcase
  end

  assign irq_o = ctrl_q[CB_EN] && |(stat_q & ien_q);

  // ---------------- assertions ----------------
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[CB_EN] |-> !irq_o);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |=> stat_q[0]);

  p_rov_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> stat_q[ROV_BIT]);

  p_swr_not_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!ctrl_q[CB_SWR] && cnt == '0 && stat_q == '0));

  p_ctrl_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ((ctrl_q & CTRL_ZERO_MASK) == '0));
endmodule

// File: tb/test_cmp_timer.sv
module test_cmp_timer;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_RUN = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 43;
  localparam vec_t TBL [NV] = '{
    '{OP_RD,  8'd0,  32'h0,         32'h0,         8'd12}, // R12 ctrl after reset
    '{OP_RD,  8'd16, 32'h0,         32'hFFFF_FFFF, 8'd12}, // R12 cmp1 reset
    '{OP_RD,  8'd8,  32'h0,         32'h0,         8'd12}, // R12 flags reset
    '{OP_WR,  8'd0,  32'h0000_7FFF, 32'h0,         8'd2},
    '{OP_RD,  8'd0,  32'h0,         32'h0000_03EB, 8'd2},  // R2 masked bits
    '{OP_WR,  8'd0,  32'h0,         32'h0,         8'd2},
    '{OP_WR,  8'd16, 32'd3,         32'h0,         8'd3},
    '{OP_WR,  8'd0,  32'h3,         32'h0,         8'd13},
    '{OP_RUN, 8'd0,  32'd2,         32'h0,         8'd3},
    '{OP_RD,  8'd36, 32'h0,         32'd2,         8'd3},  // R3 counting
    '{OP_RUN, 8'd0,  32'd1,         32'h0,         8'd5},
    '{OP_RD,  8'd8,  32'h0,         32'h1,         8'd5},  // R5 cmp1 flag
    '{OP_RUN, 8'd0,  32'd1,         32'h0,         8'd3},
    '{OP_RD,  8'd36, 32'h0,         32'd0,         8'd3},  // R3 period wrap
    '{OP_WR,  8'd8,  32'h0,         32'h0,         8'd7},
    '{OP_RD,  8'd8,  32'h0,         32'h1,         8'd7},  // R7 zero keeps
    '{OP_WR,  8'd8,  32'h1,         32'h0,         8'd7},
    '{OP_RD,  8'd8,  32'h0,         32'h0,         8'd7},  // R7 one clears
    '{OP_WR,  8'd0,  32'h203,       32'h0,         8'd4},
    '{OP_WR,  8'd20, 32'd2,         32'h0,         8'd6},
    '{OP_RUN, 8'd0,  32'd5,         32'h0,         8'd4},
    '{OP_RD,  8'd36, 32'h0,         32'd5,         8'd4},  // R4 free-run passes cmp1
    '{OP_RD,  8'd8,  32'h0,         32'h3,         8'd5},  // R5 flags 0,1
    '{OP_WR,  8'd16, 32'd100,       32'h0,         8'd6},
    '{OP_WR,  8'd24, 32'd50,        32'h0,         8'd6},
    '{OP_RD,  8'd36, 32'h0,         32'd5,         8'd6},  // R6 no disturb
    '{OP_WR,  8'd0,  32'h3,         32'h0,         8'd6},
    '{OP_RD,  8'd36, 32'h0,         32'd5,         8'd13}, // R13 no rise, kept
    '{OP_WR,  8'd16, 32'd100,       32'h0,         8'd6},
    '{OP_RD,  8'd36, 32'h0,         32'd0,         8'd6},  // R6 restart clear
    '{OP_WR,  8'd4,  32'h0000_1002, 32'h0,         8'd10},
    '{OP_RD,  8'd4,  32'h0,         32'd2,         8'd10}, // R10 12 bits
    '{OP_WR,  8'd8,  32'h3F,        32'h0,         8'd7},
    '{OP_RUN, 8'd0,  32'd6,         32'h0,         8'd10},
    '{OP_RD,  8'd36, 32'h0,         32'd2,         8'd10}, // R10 divide by 3
    '{OP_WR,  8'd0,  32'h2,         32'h0,         8'd13},
    '{OP_RUN, 8'd0,  32'd6,         32'h0,         8'd13},
    '{OP_RD,  8'd36, 32'h0,         32'd2,         8'd13}, // R13 frozen
    '{OP_WR,  8'd12, 32'hFF,        32'h0,         8'd8},
    '{OP_RD,  8'd12, 32'h0,         32'h3F,        8'd8},  // R8
    '{OP_WR,  8'd44, 32'hFFFF_FFFF, 32'h0,         8'd1},
    '{OP_RD,  8'd44, 32'h0,         32'h0,         8'd1},  // R1 unmapped
    '{OP_RD,  8'd17, 32'h0,         32'd100,       8'd1}   // R1 low addr bits
  };

  logic          clk, rst_n, tick_en, we, tgt;
  logic [AW-1:0] addr;
  logic [31:0]   wdata, rdata_a, rdata_b, rdata;
  logic          irq_a, irq_b, irq;
  int            checks, errors;

  assign rdata = tgt ? rdata_b : rdata_a;
  assign irq   = tgt ? irq_b : irq_a;

  cmp_timer #(.ADDR_W(AW), .CNT_W(32)) i_cmp_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_we(we && !tgt),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata_a), .irq_o(irq_a));

  cmp_timer #(.ADDR_W(AW), .CNT_W(8)) i_cmp_timer_w8 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_we(we && tgt),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata_b), .irq_o(irq_b));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a[AW-1:0]; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a[AW-1:0];
    #1;
    check(rdata, exp, tag);
  endtask

  task automatic run(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; tick_en = 1'b0; we = 1'b0; tgt = 1'b0;
    addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // ---- table walk on the 32-bit instance ----
    for (int i = 0; i < NV; i++) begin
      case (TBL[i].op)
        OP_WR:  wr(TBL[i].addr, TBL[i].data);
        OP_RUN: run(int'(TBL[i].data));
        default: rd(TBL[i].addr, TBL[i].exp, $sformatf("R%0d vec%0d", TBL[i].req, i));
      endcase
    end

    // R1 capture slot reads zero
    rd(8'd28, 32'h0, "R1 capture");

    // R11 soft reset keeps low control bits, reloads the rest
    wr(8'd0, 32'h0000_83FF);
    rd(8'd0,  32'h0000_01EB,  "R11 ctrl kept");
    rd(8'd16, 32'hFFFF_FFFF,  "R11 cmp1");
    rd(8'd24, 32'hFFFF_FFFF,  "R11 cmp3");
    rd(8'd4,  32'h0,          "R11 presc");
    rd(8'd12, 32'h0,          "R11 mask");
    rd(8'd36, 32'h0,          "R11 count");

    // ---- 8-bit instance: rollover corner ----
    tgt = 1'b1;
    wr(8'd12, 32'h20);
    wr(8'd0,  32'h203);
    #1 check({31'b0, irq}, 32'h0, "R9 irq low before wrap");
    run(255);
    rd(8'd36, 32'hFF, "R4 at top");
    rd(8'd8,  32'h07, "R5 all compares at top");
    check({31'b0, irq}, 32'h0, "R9 masked flags");
    run(1);
    rd(8'd36, 32'h00, "R4 wrapped");
    rd(8'd8,  32'h27, "R4 rollover flag");
    check({31'b0, irq}, 32'h1, "R9 irq on rollover");
    wr(8'd0, 32'h202);
    #1 check({31'b0, irq}, 32'h0, "R9 irq gated by enable");
    rd(8'd8, 32'h27, "R9 flags kept when disabled");

    // R7 set wins over same-cycle clear
    wr(8'd8, 32'h3F);
    wr(8'd0, 32'h0);
    wr(8'd0, 32'h3);
    wr(8'd16, 32'd4);
    rd(8'd36, 32'h0, "R13 rise with enable-mode clears");
    @(negedge clk);
    tick_en = 1'b1;
    repeat (3) @(negedge clk);
    addr = 6'd8; wdata = 32'h1; we = 1'b1;
    @(negedge clk);
    we = 1'b0; tick_en = 1'b0;
    rd(8'd8,  32'h1, "R7 set wins");
    rd(8'd36, 32'd4, "R5 count at cmp1");

    // R13 rise without enable-mode keeps count
    wr(8'd0, 32'h0);
    wr(8'd0, 32'h1);
    rd(8'd36, 32'd4, "R13 rise keeps count");
    run(1);
    rd(8'd36, 32'd0, "R3 wrap at cmp1 after re-enable");

    // ---- R12 hard reset ----
    tgt = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rd(8'd0,  32'h0,         "R12 ctrl cleared");
    rd(8'd16, 32'hFFFF_FFFF, "R12 cmp1");
    rd(8'd36, 32'h0,         "R12 count");
    check({31'b0, irq}, 32'h0, "R12 irq low");
    rst_n = 1'b1;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule